// File: doc/BRIEF.md
# Multi-Mode Timer with Variable-Width PWM

This block is a 16-bit counting engine with four modes, chosen by a control register. It can run as two independent 8-bit interval timers, as an 8-bit interval timer beside an 8-bit pulse-width modulator, as one 16-bit interval timer, or as a pulse-width modulator whose period spans 2^N counts, with N programmable from 9 to 16. Its interrupt events come out as two one-cycle strobes, one for the lower half and one for the upper half. Another unit routes them to the interrupt controller.

Counting advances on strobes from the clock domain's cycle generator. `tick_full` arrives once per instruction cycle and `tick_half` once per half cycle. The two 8-bit modes always count on `tick_full`. The two 16-bit modes count on either strobe, as a control bit selects. The PWM duty value sits in a shadow register that reloads only when the period wraps, so a duty value written mid-period never shortens or stretches the current pulse.

The control is a five-state machine. `ST_STOP` is the idle state. `ST_SPLIT` (mode 0), `ST_TPWM` (mode 1), `ST_WIDE` (mode 2) and `ST_VPWM` (mode 3) are the running states. There is one kind of transition. A control write with the run bit set moves to the running state for the written mode, from any state, including the state it is already in. A control write with the run bit clear moves to `ST_STOP`. Every control write clears both counter halves. No other event changes the state.

Top module: `tmr_pwm16`

## Requirements
- R1: After reset, `pwm_out`, `irq_lo` and `irq_hi` are 0 and the block is in `ST_STOP`.
- R2: Mode 0 runs two independent timers. The lower half counts 0..LO on `tick_full` and then wraps. The upper half counts 0..HI and then wraps. A tick that wraps the lower half raises `irq_lo` for one cycle after that clock edge. A tick that wraps the upper half raises `irq_hi` in the same way.
- R3: Mode 1 runs the lower half as in R2. The upper half is a free-running 8-bit PWM counter with a period of 256 ticks. `pwm_out` is 1 while that count is below the duty value held in HI. Each wrap of this counter raises `irq_hi`.
- R4: Mode 2 counts one 16-bit value from 0 to {HI,LO} and then wraps. Each wrap raises `irq_hi`. `irq_lo` stays 0 in modes 2 and 3.
- R5: Mode 3 counts from 0 to 2^N−1 and then wraps. N equals 9 plus the width field. Each wrap raises `irq_hi`.
- R6: In mode 3, `pwm_out` is 1 while the count is below the active 16-bit duty value {HI,LO}. A duty of 0 keeps the output at 0. A duty of 2^N or more keeps it at 1. `pwm_out` is 0 in modes 0 and 2.
- R7: A duty value written while a PWM mode is running takes effect only at the first period wrap after the write.
- R8: Modes 0 and 1 ignore `tick_half`. In modes 2 and 3, the half-resolution bit set makes the counter step on `tick_half` only, and the bit clear makes it step on `tick_full` only.
- R9: Every control write clears both counter halves and restarts counting from 0. A control write with the run bit clear stops counting and holds all three outputs at 0.
- R10: Register map (`wr_addr`):
  - Address 0 is control: bits 1:0 hold the mode, bit 2 the half-resolution select, bit 3 run, and bits 6:4 the width field.
  - Address 1 holds LO and address 2 holds HI.
  - Writes take effect at the clock edge that samples `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_full | input | 1 | One-cycle strobe, once per instruction cycle |
| tick_half | input | 1 | One-cycle strobe, once per half instruction cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 LO, 2 HI |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | Modulated output |
| irq_lo | output | 1 | Lower-half interrupt event, one cycle |
| irq_hi | output | 1 | Upper-half or full-width interrupt event, one cycle |

## Verification
The hardest case to reach from the ports is a duty rewrite that lands partway through a running period. To pass, the old duty must keep governing every remaining count and the new one must govern from the wrap onwards. The stimulus reaches this case by letting each PWM mode run past at least one wrap, writing a new duty with no tick in that cycle, and then running for more than a full period. The scoreboard's reference model tracks the shadow separately from the register, so it flags any early change. Resolution switching gets a similar treatment. The 16-bit modes are driven with `tick_full` still toggling while half resolution is selected, and again with only `tick_full`, so a counter that uses the wrong strobe shows up as drift.

// File: rtl/tmr_pwm_pkg.sv
package tmr_pwm_pkg;

    typedef enum logic [2:0] {
        ST_STOP,
        ST_SPLIT,
        ST_TPWM,
        ST_WIDE,
        ST_VPWM
    } tmr_state_e;

    typedef enum logic [1:0] {
        MD_SPLIT = 2'd0,
        MD_TPWM  = 2'd1,
        MD_WIDE  = 2'd2,
        MD_VPWM  = 2'd3
    } tmr_mode_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LO   = 2'd1;
    localparam logic [1:0] A_HI   = 2'd2;

    // Control register field positions
    localparam int C_MODE_LSB = 0;
    localparam int C_HALF_BIT = 2;
    localparam int C_RUN_BIT  = 3;
    localparam int C_WSEL_LSB = 4;

    function automatic tmr_state_e run_state(input tmr_mode_e m);
        tmr_state_e s;
        unique case (m)
            MD_SPLIT: s = ST_SPLIT;
            MD_TPWM:  s = ST_TPWM;
            MD_WIDE:  s = ST_WIDE;
            MD_VPWM:  s = ST_VPWM;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel (
    input  logic tick_full,
    input  logic tick_half,
    input  logic use_half,
    output logic step
);
    // One step strobe per selected resolution
    assign step = use_half ? tick_half : tick_full;
endmodule

// File: rtl/tmr_cnt_slice.sv
module tmr_cnt_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         wrap,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc) begin
            q <= wrap ? '0 : q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_pwm_gen.sv
module tmr_pwm_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cnt,
    input  logic         en,
    output logic         pwm
);
    logic [W-1:0] duty_q;

    // Shadow duty: replaced only when the controller asks (wrap, stop, restart)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '0;
        end else if (load) begin
            duty_q <= load_val;
        end
    end

    assign pwm = en && (cnt < duty_q);
endmodule

// File: rtl/tmr_pwm16.sv
module tmr_pwm16
    import tmr_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_full,
    input  logic                 tick_half,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [CNT_W/2-1:0]   wr_data,
    output logic                 pwm_out,
    output logic                 irq_lo,
    output logic                 irq_hi
);
    localparam int HALF_W = CNT_W / 2;
    localparam int WSEL_W = $clog2(HALF_W);
    localparam int NSLICE = 2;

    // ---------------- register writes ----------------
    logic ctrl_wr, lo_wr, hi_wr;
    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign lo_wr   = wr_en && (wr_addr == A_LO);
    assign hi_wr   = wr_en && (wr_addr == A_HI);

    tmr_mode_e         wr_mode;
    logic              wr_run;
    logic              ctrl_spare_unused;
    assign wr_mode = tmr_mode_e'(wr_data[C_MODE_LSB +: 2]);
    assign wr_run  = wr_data[C_RUN_BIT];
    assign ctrl_spare_unused = ^wr_data[HALF_W-1:C_WSEL_LSB+WSEL_W];

    tmr_mode_e         mode_q;
    logic              half_q;
    logic [WSEL_W-1:0] wsel_q;
    logic [HALF_W-1:0] cmp_lo_q, cmp_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MD_SPLIT;
            half_q   <= 1'b0;
            wsel_q   <= '0;
            cmp_lo_q <= '0;
            cmp_hi_q <= '0;
        end else begin
            if (ctrl_wr) begin
                mode_q <= wr_mode;
                half_q <= wr_data[C_HALF_BIT];
                wsel_q <= wr_data[C_WSEL_LSB +: WSEL_W];
            end
            if (lo_wr) cmp_lo_q <= wr_data;
            if (hi_wr) cmp_hi_q <= wr_data;
        end
    end

    // ---------------- state machine ----------------
    tmr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            state_d = wr_run ? run_state(wr_mode) : ST_STOP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // ---------------- step selection ----------------
    logic wide_state, use_half, step;
    assign wide_state = (state_q == ST_WIDE) || (state_q == ST_VPWM);
    assign use_half   = wide_state && half_q;

    tmr_tick_sel u_tick_sel (
        .tick_full (tick_full),
        .tick_half (tick_half),
        .use_half  (use_half),
        .step      (step)
    );

    // ---------------- counter slices ----------------
    logic [NSLICE-1:0]             inc_v, wrp_v;
    logic [NSLICE-1:0][HALF_W-1:0] slice_q;
    logic                          cnt_clr;
    assign cnt_clr = ctrl_wr || (state_q == ST_STOP);

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        tmr_cnt_slice #(.W(HALF_W)) u_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (inc_v[g]),
            .wrap  (wrp_v[g]),
            .q     (slice_q[g])
        );
    end

    logic [HALF_W-1:0] cnt_lo, cnt_hi;
    logic [CNT_W-1:0]  cnt_full;
    assign cnt_lo   = slice_q[0];
    assign cnt_hi   = slice_q[1];
    assign cnt_full = {cnt_hi, cnt_lo};

    // Variable period mask: N = HALF_W+1+wsel bits
    logic [CNT_W-1:0] vmask, wide_lim;
    assign vmask    = {CNT_W{1'b1}} >> (HALF_W - 1 - int'(wsel_q));
    assign wide_lim = (state_q == ST_WIDE) ? {cmp_hi_q, cmp_lo_q} : vmask;

    logic lo_hit, hi_hit, lo_top, hi_top, full_hit;
    assign lo_hit   = (cnt_lo == cmp_lo_q);
    assign hi_hit   = (cnt_hi == cmp_hi_q);
    assign lo_top   = &cnt_lo;
    assign hi_top   = &cnt_hi;
    assign full_hit = (cnt_full == wide_lim);

    // ---------------- state outputs ----------------
    logic             ev_lo, ev_hi, pwm_en;
    logic [CNT_W-1:0] pwm_cnt;

    always_comb begin
        inc_v   = '0;
        wrp_v   = '0;
        ev_lo   = 1'b0;
        ev_hi   = 1'b0;
        pwm_en  = 1'b0;
        pwm_cnt = cnt_full;
        unique case (state_q)
            ST_STOP: begin
            end
            ST_SPLIT: begin
                inc_v = {step, step};
                wrp_v = {hi_hit, lo_hit};
                ev_lo = step && lo_hit;
                ev_hi = step && hi_hit;
            end
            ST_TPWM: begin
                inc_v   = {step, step};
                wrp_v   = {hi_top, lo_hit};
                ev_lo   = step && lo_hit;
                ev_hi   = step && hi_top;
                pwm_en  = 1'b1;
                pwm_cnt = {{HALF_W{1'b0}}, cnt_hi};
            end
            ST_WIDE, ST_VPWM: begin
                inc_v  = {step && (lo_top || full_hit), step};
                wrp_v  = {full_hit, full_hit};
                ev_hi  = step && full_hit;
                pwm_en = (state_q == ST_VPWM);
            end
        endcase
    end

    // Registered interrupt strobes; a control write suppresses them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
        end else begin
            irq_lo <= ev_lo && !ctrl_wr;
            irq_hi <= ev_hi && !ctrl_wr;
        end
    end

    // ---------------- duty shadow ----------------
    logic [CNT_W-1:0] src_cur, src_new, load_val;
    logic             duty_load;
    assign src_cur   = (mode_q  == MD_TPWM) ? {{HALF_W{1'b0}}, cmp_hi_q} : {cmp_hi_q, cmp_lo_q};
    assign src_new   = (wr_mode == MD_TPWM) ? {{HALF_W{1'b0}}, cmp_hi_q} : {cmp_hi_q, cmp_lo_q};
    assign load_val  = ctrl_wr ? src_new : src_cur;
    assign duty_load = ctrl_wr || (state_q == ST_STOP) || (pwm_en && ev_hi);

    tmr_pwm_gen #(.W(CNT_W)) u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (duty_load),
        .load_val (load_val),
        .cnt      (pwm_cnt),
        .en       (pwm_en),
        .pwm      (pwm_out)
    );

    // ---------------- assertions ----------------
    assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> (!pwm_out && !irq_lo && !irq_hi));

    assert_wide_no_lo_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wide_state |-> !irq_lo);

    assert_vpwm_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VPWM) |-> (cnt_full <= vmask));

    assert_irq_after_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo || irq_hi) |-> $past(step));

    assert_split_hi_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPLIT && $past(state_q) == ST_SPLIT && irq_hi) |-> (cnt_hi == '0));

    assert_tpwm_hi_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TPWM && $past(state_q) == ST_TPWM && irq_hi) |-> (cnt_hi == '0));

endmodule

// File: tb/tb_tmr_pwm16.sv
module tb_tmr_pwm16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_full = 1'b0;
    logic       tick_half = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out, irq_lo, irq_hi;

    always #4 clk = ~clk;   // 125 MHz

    tmr_pwm16 dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_full (tick_full),
        .tick_half (tick_half),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pwm_out   (pwm_out),
        .irq_lo    (irq_lo),
        .irq_hi    (irq_hi)
    );

    int    tests = 0;
    int    fails = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];
    string      cur_tag = "R1";

    // Reference model state (from the requirements)
    int m_mode = 0, m_half = 0, m_run = 0, m_wsel = 0;
    int m_clo = 0, m_chi = 0, m_lo = 0, m_hi = 0, m_duty = 0;

    function automatic int duty_src(input int md);
        return (md == 1) ? m_chi : m_chi * 256 + m_clo;
    endfunction

    function automatic int mk_ctrl(input int md, input int hf, input int rn, input int ws);
        return md | (hf << 2) | (rn << 3) | (ws << 4);
    endfunction

    // Driver: one clock cycle of stimulus, model update, expected item pushed
    task automatic cyc(input bit tf, input bit th, input bit we, input int addr, input int data);
        int c;
        int lim;
        bit e_lo, e_hi, stp, p;
        @(negedge clk);
        tick_full = tf;
        tick_half = th;
        wr_en     = we;
        wr_addr   = 2'(addr);
        wr_data   = 8'(data);
        e_lo = 1'b0;
        e_hi = 1'b0;
        if (we) begin
            if (addr == 0) begin
                m_mode = data & 3;
                m_half = (data >> 2) & 1;
                m_run  = (data >> 3) & 1;
                m_wsel = (data >> 4) & 7;
                m_lo = 0;
                m_hi = 0;
                m_duty = duty_src(m_mode);
            end else if (addr == 1) begin
                m_clo = data;
            end else if (addr == 2) begin
                m_chi = data;
            end
        end else if (m_run != 0) begin
            stp = (m_mode >= 2 && m_half != 0) ? th : tf;
            if (stp) begin
                if (m_mode == 0 || m_mode == 1) begin
                    if (m_lo == m_clo) begin m_lo = 0; e_lo = 1'b1; end
                    else m_lo++;
                end
                if (m_mode == 0) begin
                    if (m_hi == m_chi) begin m_hi = 0; e_hi = 1'b1; end
                    else m_hi++;
                end else if (m_mode == 1) begin
                    if (m_hi == 255) begin m_hi = 0; e_hi = 1'b1; m_duty = m_chi; end
                    else m_hi++;
                end else begin
                    c   = m_hi * 256 + m_lo;
                    lim = (m_mode == 2) ? m_chi * 256 + m_clo : (1 << (9 + m_wsel)) - 1;
                    if (c == lim) begin
                        c = 0;
                        e_hi = 1'b1;
                        if (m_mode == 3) m_duty = m_chi * 256 + m_clo;
                    end else begin
                        c++;
                    end
                    m_hi = c >> 8;
                    m_lo = c & 255;
                end
            end
        end
        p = (m_run != 0) &&
            ((m_mode == 1 && m_hi < m_duty) ||
             (m_mode == 3 && (m_hi * 256 + m_lo) < m_duty));
        exp_q.push_back({e_lo, e_hi, p});
        tag_q.push_back(cur_tag);
    endtask

    task automatic wr(input int addr, input int data);
        cyc(1'b0, 1'b0, 1'b1, addr, data);
    endtask

    task automatic ticks(input int n, input int every, input bit tf, input bit th);
        for (int i = 0; i < n; i++) begin
            if (i % every == 0) cyc(tf, th, 1'b0, 0, 0);
            else                cyc(1'b0, 1'b0, 1'b0, 0, 0);
        end
    endtask

    // Monitor: pops one expected item per cycle, compares away from the edge
    initial begin
        logic [2:0] e;
        logic [2:0] got;
        string t;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                got = {irq_lo, irq_hi, pwm_out};
                tests++;
                if (got !== e) begin
                    fails++;
                    $display("FAIL %s: irq_lo/irq_hi/pwm got %b expected %b at %0t", t, got, e, $time);
                end
            end
        end
    end

    task automatic check_now(input string tag, input logic [2:0] got, input logic [2:0] e);
        tests++;
        if (got !== e) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, e);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check_now("R1", {irq_lo, irq_hi, pwm_out}, 3'b000);
        end
        rst_n = 1'b1;
        cur_tag = "R1";
        ticks(4, 1, 1'b1, 1'b1);

        // R10 / R2: split timers, LO=3 HI=5
        cur_tag = "R10";
        wr(1, 3);
        wr(2, 5);
        wr(0, mk_ctrl(0, 0, 1, 0));
        cur_tag = "R2";
        ticks(30, 1, 1'b1, 1'b0);
        ticks(20, 2, 1'b1, 1'b0);

        // R8: half ticks ignored in split mode
        cur_tag = "R8";
        ticks(14, 1, 1'b0, 1'b1);

        // R3: timer + 8-bit PWM, duty 64
        cur_tag = "R3";
        wr(1, 2);
        wr(2, 64);
        wr(0, mk_ctrl(1, 0, 1, 0));
        ticks(300, 1, 1'b1, 1'b1);
        // R7: duty change mid-period
        cur_tag = "R7";
        wr(2, 200);
        ticks(400, 1, 1'b1, 1'b0);
        // R6: zero duty in mode 1 after wrap
        cur_tag = "R6";
        wr(2, 0);
        ticks(300, 1, 1'b1, 1'b0);

        // R4: 16-bit timer with limit 0x0110
        cur_tag = "R4";
        wr(1, 8'h10);
        wr(2, 8'h01);
        wr(0, mk_ctrl(2, 0, 1, 0));
        ticks(400, 1, 1'b1, 1'b0);
        ticks(300, 3, 1'b1, 1'b1);
        // R8: half resolution in 16-bit mode
        cur_tag = "R8";
        wr(0, mk_ctrl(2, 1, 1, 0));
        for (int i = 0; i < 320; i++) cyc(i[0], 1'b1, 1'b0, 0, 0);
        ticks(60, 1, 1'b1, 1'b0);

        // R5: variable PWM N=9, duty 100
        cur_tag = "R5";
        wr(1, 100);
        wr(2, 0);
        wr(0, mk_ctrl(3, 0, 1, 0));
        ticks(1100, 1, 1'b1, 1'b0);
        // R7: new duty 0x180 mid-period
        cur_tag = "R7";
        wr(1, 8'h80);
        wr(2, 8'h01);
        ticks(700, 1, 1'b1, 1'b0);

        // R6: duty >= 2^N holds high (N=10, duty 1024)
        cur_tag = "R6";
        wr(1, 0);
        wr(2, 4);
        wr(0, mk_ctrl(3, 0, 1, 1));
        ticks(1100, 1, 1'b1, 1'b0);
        // R6: zero duty after wrap holds low
        wr(2, 0);
        ticks(1100, 1, 1'b1, 1'b0);

        // R5: N=11 with half resolution, duty 1500
        cur_tag = "R5";
        wr(1, 1500 & 255);
        wr(2, 1500 >> 8);
        wr(0, mk_ctrl(3, 1, 1, 2));
        ticks(2100, 1, 1'b0, 1'b1);

        // R9: stop and restart
        cur_tag = "R9";
        wr(0, mk_ctrl(3, 0, 0, 2));
        ticks(20, 1, 1'b1, 1'b1);
        wr(1, 0);
        wr(2, 0);
        wr(0, mk_ctrl(0, 0, 1, 0));
        ticks(10, 1, 1'b1, 1'b0);
        wr(0, mk_ctrl(1, 0, 1, 0));
        ticks(5, 1, 1'b1, 1'b0);
        wr(0, mk_ctrl(1, 0, 0, 0));
        ticks(6, 1, 1'b1, 1'b1);

        repeat (4) @(posedge clk);
        #3;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule